// File: doc/BRIEF.md
# Mixed-precision packed multiply-accumulate unit

This execution unit sits beside a 32-bit RISC-V integer pipeline and recognises five custom three-register instructions by itself. One instruction seeds a private 32-bit accumulator. One returns the accumulator to the destination register. Three perform packed signed multiply-accumulate on the two source register values. A MAC splits both 32-bit operands into equal signed lanes of 8, 4 or 2 bits, multiplies lanes with the same index, and adds every product into the accumulator.

The pipeline hands over the raw instruction word, both source values and a valid strobe. The unit answers combinationally in the same cycle with a write-enable and result data. The accumulator changes on the clock edge that ends the cycle. The unit therefore accepts one instruction every cycle and never stalls. Software clears the accumulator by seeding it with zero.

Top module: `mpmac_unit`

## Requirements
- R1: An instruction is recognised when (instr & 0xFE00707F) equals its pattern. The rd (bits 11:7), rs1 (bits 19:15) and rs2 (bits 24:20) fields may hold any value.
- R2: All five instructions use opcode 0x47. The seed instruction, with funct3=1 and funct7=0 (pattern 0x00001047), loads the accumulator with src_a on the next edge and does not raise the write-enable.
- R3: The read instruction, with funct3=4 and funct7=0 (pattern 0x00004047), raises the write-enable and drives the accumulator value on the result port in the same cycle. It leaves the accumulator unchanged.
- R4: The 8-bit MAC (pattern 0x10002047, funct7=0x08, funct3=2) adds the sum of four signed products to the accumulator. Lane i is bits [8i+7:8i] of each operand.
- R5: The 4-bit MAC (pattern 0x08002047, funct7=0x04) adds the sum of eight signed products. Lane i is bits [4i+3:4i] of each operand.
- R6: The 2-bit MAC (pattern 0x04002047, funct7=0x02) adds the sum of sixteen signed products. Lane i is bits [2i+1:2i] of each operand.
- R7: Accumulation wraps modulo 2^32.
- R8: Synchronous active-high reset sets the accumulator to zero.
- R9: While valid is low, or when the word matches no pattern, the accumulator does not change and the write-enable stays low.
- R10: Back-to-back MACs in consecutive cycles each add to the accumulator, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction strobe for this cycle |
| in_instr | input | 32 | Raw instruction word |
| in_src_a | input | 32 | rs1 value |
| in_src_b | input | 32 | rs2 value |
| out_we | output | 1 | Destination write-enable |
| out_data | output | 32 | Destination write data |

## Verification
Each lane width is first swept with both operands broadcast across all lanes, over the full signed lane range at 2 and 4 bits and a strided range at 8 bits. A wrong sign extension or a wrong product count therefore shows up as a wrong multiple. Random operands follow, in which every lane differs, so that lane misalignment or a mixed-up lane pairing is exposed. Lanes at the most negative value test sign handling at the extremes. A seed near the top of the range exposes a missing wrap. Near-miss instruction words, words with the free fields filled, idle cycles and a reset in mid-run separate decode mistakes from datapath mistakes.

// File: rtl/mpmac_pkg.sv
package mpmac_pkg;

    localparam int XLEN = 32;
    localparam logic [31:0] FIXED_MASK = 32'hFE00707F;

    localparam logic [31:0] PAT_SEED = 32'h00001047;
    localparam logic [31:0] PAT_READ = 32'h00004047;
    localparam logic [31:0] PAT_MAC8 = 32'h10002047;
    localparam logic [31:0] PAT_MAC4 = 32'h08002047;
    localparam logic [31:0] PAT_MAC2 = 32'h04002047;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_SEED,
        OP_READ,
        OP_MAC8,
        OP_MAC4,
        OP_MAC2
    } op_kind_e;

    typedef struct packed {
        logic            wr;
        logic [XLEN-1:0] data;
    } wb_t;

    function automatic op_kind_e classify(input logic [31:0] word);
        logic [31:0] fixed_bits;
        fixed_bits = word & FIXED_MASK;
        case (fixed_bits)
            PAT_SEED: return OP_SEED;
            PAT_READ: return OP_READ;
            PAT_MAC8: return OP_MAC8;
            PAT_MAC4: return OP_MAC4;
            PAT_MAC2: return OP_MAC2;
            default:  return OP_NONE;
        endcase
    endfunction

endpackage

// File: rtl/mpmac_decode.sv
module mpmac_decode
    import mpmac_pkg::*;
(
    input  logic        valid,
    input  logic [31:0] instr,
    output op_kind_e    op
);
    always_comb begin
        op = OP_NONE;
        if (valid) begin
            op = classify(instr);
        end
    end
endmodule

// File: rtl/mpmac_lanes.sv
module mpmac_lanes #(
    parameter int XW = 32,
    parameter int LW = 8
) (
    input  logic [XW-1:0] opa,
    input  logic [XW-1:0] opb,
    output logic [XW-1:0] dot
);
    localparam int NL = XW / LW;

    logic [XW-1:0] prod [NL];

    genvar g;
    generate
        for (g = 0; g < NL; g++) begin : g_lane
            logic signed [LW-1:0] la;
            logic signed [LW-1:0] lb;
            logic signed [XW-1:0] wa;
            logic signed [XW-1:0] wb;
            assign la = opa[g*LW +: LW];
            assign lb = opb[g*LW +: LW];
            assign wa = XW'(la);
            assign wb = XW'(lb);
            assign prod[g] = XW'(wa * wb);
        end
    endgenerate

    always_comb begin
        dot = '0;
        for (int i = 0; i < NL; i++) begin
            dot = dot + prod[i];
        end
    end
endmodule

// File: rtl/mpmac_unit.sv
module mpmac_unit
    import mpmac_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [31:0] in_instr,
    input  logic [31:0] in_src_a,
    input  logic [31:0] in_src_b,
    output logic        out_we,
    output logic [31:0] out_data
);
    localparam int NMODE = 3;

    op_kind_e        op;
    logic [XLEN-1:0] acc_q;
    logic [XLEN-1:0] acc_d;
    logic [XLEN-1:0] dots [NMODE];
    wb_t             wb;

    mpmac_decode u_dec (
        .valid (in_valid),
        .instr (in_instr),
        .op    (op)
    );

    genvar m;
    generate
        for (m = 0; m < NMODE; m++) begin : g_mode
            mpmac_lanes #(
                .XW (XLEN),
                .LW (8 >> m)
            ) u_lanes (
                .opa (in_src_a),
                .opb (in_src_b),
                .dot (dots[m])
            );
        end
    endgenerate

    always_comb begin
        acc_d = acc_q;
        case (op)
            OP_SEED: acc_d = in_src_a;
            OP_MAC8: acc_d = acc_q + dots[0];
            OP_MAC4: acc_d = acc_q + dots[1];
            OP_MAC2: acc_d = acc_q + dots[2];
            default: acc_d = acc_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    always_comb begin
        wb.wr   = (op == OP_READ);
        wb.data = wb.wr ? acc_q : '0;
    end

    assign out_we   = wb.wr;
    assign out_data = wb.data;
endmodule

// File: rtl/mpmac_checks.sv
module mpmac_checks (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [31:0] in_instr,
    input logic [31:0] in_src_a,
    input logic        out_we,
    input logic [31:0] acc_q
);
    logic [31:0] fixed;
    logic        is_known;
    logic        is_read;
    logic        is_seed;
    logic        past_rst_seen;

    assign fixed    = in_instr & 32'hFE00707F;
    assign is_read  = (fixed == 32'h00004047);
    assign is_seed  = (fixed == 32'h00001047);
    assign is_known = is_read || is_seed || (fixed == 32'h10002047)
                   || (fixed == 32'h08002047) || (fixed == 32'h04002047);

    always_ff @(posedge clk) begin
        past_rst_seen <= rst;
    end

    // R8: accumulator is zero in the cycle after reset
    p_clear_on_reset_r8: assert property (@(posedge clk)
        past_rst_seen && !rst |-> acc_q == 32'h0);

    // R2: seed loads src_a on the next edge
    p_seed_loads_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid && is_seed |=> acc_q == $past(in_src_a));

    // R9: idle or unknown word keeps the accumulator
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (!in_valid || !is_known) |=> $stable(acc_q));

    // R9: no write without a valid read word
    p_we_only_read_r9: assert property (@(posedge clk) disable iff (rst)
        out_we |-> in_valid && is_read);

    // R3: read leaves the accumulator unchanged
    p_read_keeps_r3: assert property (@(posedge clk) disable iff (rst)
        in_valid && is_read |=> $stable(acc_q));

    // R3: valid read always writes
    p_read_writes_r3: assert property (@(posedge clk) disable iff (rst)
        in_valid && is_read |-> out_we);
endmodule

bind mpmac_unit mpmac_checks u_checks (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_instr (in_instr),
    .in_src_a (in_src_a),
    .out_we   (out_we),
    .acc_q    (acc_q)
);

// File: tb/tb_mpmac_unit.sv
module tb_mpmac_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] in_instr;
    logic [31:0] in_src_a;
    logic [31:0] in_src_b;
    logic        out_we;
    logic [31:0] out_data;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 1'b0;
    logic [31:0] model;

    localparam logic [31:0] I_SEED = 32'h00001047;
    localparam logic [31:0] I_READ = 32'h00004047;
    localparam logic [31:0] I_MAC8 = 32'h10002047;
    localparam logic [31:0] I_MAC4 = 32'h08002047;
    localparam logic [31:0] I_MAC2 = 32'h04002047;
    localparam logic [31:0] FREE   = 32'h01FF8F80;

    mpmac_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_instr(in_instr),
        .in_src_a(in_src_a), .in_src_b(in_src_b),
        .out_we(out_we), .out_data(out_data)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] ref_dot(input int w, input logic [31:0] a, input logic [31:0] b);
        int s = 0;
        for (int i = 0; i < 32 / w; i++) begin
            int x = 0;
            int y = 0;
            for (int k = 0; k < w; k++) begin
                x += int'(a[i*w+k]) << k;
                y += int'(b[i*w+k]) << k;
            end
            if (x >= (1 << (w - 1))) x -= (1 << w);
            if (y >= (1 << (w - 1))) y -= (1 << w);
            s += x * y;
        end
        return 32'(s);
    endfunction

    function automatic logic [31:0] bcast(input int w, input int v);
        logic [31:0] r = '0;
        for (int i = 0; i < 32 / w; i++) begin
            for (int k = 0; k < w; k++) r[i*w+k] = v[k];
        end
        return r;
    endfunction

    function automatic logic [31:0] mac_word(input int w);
        if (w == 8) return I_MAC8;
        if (w == 4) return I_MAC4;
        return I_MAC2;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at negedge, optionally check the write-enable, then let the edge happen
    task automatic issue(input bit v, input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                         input string req);
        @(negedge clk);
        in_valid = v; in_instr = ins; in_src_a = a; in_src_b = b;
        #2;
        check(out_we == 1'b0, req, {31'b0, out_we}, 32'h0);
        @(posedge clk);
    endtask

    task automatic read_check(input logic [31:0] exp, input string req);
        @(negedge clk);
        in_valid = 1'b1; in_instr = I_READ | ($urandom & FREE); in_src_a = $urandom; in_src_b = $urandom;
        #2;
        check(out_we === 1'b1 && out_data === exp, req, out_data, exp);
        @(posedge clk);
    endtask

    task automatic do_mac(input int w, input logic [31:0] a, input logic [31:0] b, input string req);
        issue(1'b1, mac_word(w), a, b, req);
        model = model + ref_dot(w, a, b);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !done) begin
                done = 1'b1;
                bad++; total++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_instr = '0; in_src_a = '0; in_src_b = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        model = 32'h0;
        read_check(32'h0, "R8 reset value");

        // R2 seed, R1 free fields
        issue(1'b1, I_SEED | FREE, 32'h1234_5678, 32'hFFFF_FFFF, "R2 seed no write");
        model = 32'h1234_5678;
        read_check(model, "R2 seed value R1 free fields");

        // R3 read twice leaves value
        read_check(model, "R3 repeated read");

        // broadcast sweeps per lane width (R4 R5 R6)
        for (int w = 2; w <= 8; w *= 2) begin
            int lo = -(1 << (w - 1));
            int hi = (1 << (w - 1)) - 1;
            int st = (w == 8) ? 15 : 1;
            issue(1'b1, I_SEED, 32'h0, 32'h0, "R2 clear");
            model = 32'h0;
            for (int u = lo; u <= hi; u += st) begin
                for (int v = lo; v <= hi; v += st) begin
                    do_mac(w, bcast(w, u), bcast(w, v), "R4 R5 R6 sweep");
                    read_check(model, w == 8 ? "R4 sweep" : (w == 4 ? "R5 sweep" : "R6 sweep"));
                end
            end
        end

        // minimum-value lanes
        issue(1'b1, I_SEED, 32'h0, 32'h0, "R2 clear");
        model = 32'h0;
        do_mac(8, 32'h8080_8080, 32'h8080_8080, "R4 min");
        read_check(32'h0001_0000, "R4 all -128 lanes");
        do_mac(4, 32'h8888_8888, 32'h8888_8888, "R5 min");
        read_check(32'h0001_0200, "R5 all -8 lanes");
        do_mac(2, 32'hAAAA_AAAA, 32'hAAAA_AAAA, "R6 min");
        read_check(32'h0001_0240, "R6 all -2 lanes");
        do_mac(8, 32'h8080_8080, 32'h7F7F_7F7F, "R4 min by max");
        read_check(model, "R4 -128 by 127");

        // random operands, back-to-back MACs (R10)
        for (int n = 0; n < 300; n++) begin
            int w = 2 << ($urandom % 3);
            if (w == 6) w = 8;
            do_mac(w, $urandom, $urandom, "R10 back to back");
            do_mac((n % 3 == 0) ? 8 : ((n % 3 == 1) ? 4 : 2), $urandom, $urandom, "R10 back to back");
            read_check(model, w == 8 ? "R4 R10 random" : (w == 4 ? "R5 R10 random" : "R6 R10 random"));
        end

        // wrap (R7)
        issue(1'b1, I_SEED, 32'h7FFF_FFFF, 32'h0, "R2 seed");
        model = 32'h7FFF_FFFF;
        do_mac(8, 32'h0101_0101, 32'h0101_0101, "R7 wrap");
        read_check(32'h8000_0003, "R7 wrap past signed max");
        issue(1'b1, I_SEED, 32'hFFFF_FFFF, 32'h0, "R2 seed");
        model = 32'hFFFF_FFFF;
        do_mac(4, 32'h0000_0001, 32'h0000_0001, "R7 wrap");
        read_check(32'h0000_0000, "R7 wrap to zero");

        // ignored stimulus (R9)
        issue(1'b1, I_SEED, 32'h0BAD_CAFE, 32'h0, "R2 seed");
        model = 32'h0BAD_CAFE;
        issue(1'b0, I_MAC8, 32'h7F7F_7F7F, 32'h7F7F_7F7F, "R9 valid low no write");
        issue(1'b0, I_READ, 32'h0, 32'h0, "R9 valid low read no write");
        issue(1'b1, 32'h20002047, 32'h7F7F_7F7F, 32'h7F7F_7F7F, "R9 bad funct7 no write");
        issue(1'b1, 32'h1000204B, 32'h7F7F_7F7F, 32'h7F7F_7F7F, "R9 bad opcode no write");
        issue(1'b1, 32'h10003047, 32'h7F7F_7F7F, 32'h7F7F_7F7F, "R9 bad funct3 no write");
        issue(1'b1, 32'h00005047, 32'h1111_1111, 32'h0, "R9 near read no write");
        read_check(model, "R9 accumulator unchanged");

        // MAC with free fields filled (R1)
        issue(1'b1, I_MAC2 | FREE, 32'h5555_5555, 32'h5555_5555, "R1 free fields mac");
        model = model + 32'd16;
        read_check(model, "R1 free fields mac result");

        // reset mid-run (R8)
        @(negedge clk); rst = 1'b1; in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk); rst = 1'b0;
        model = 32'h0;
        read_check(32'h0, "R8 reset clears accumulator");

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule